// File: doc/BRIEF.md
# CAN Message Buffer State Controller

This block keeps the status and control word of a single message slot in a multi-slot CAN controller. The word holds a 4-bit life-cycle state, a 4-bit priority and a 4-bit data length code. Software writes the word through a plain write port. The protocol engine moves the state along the receive and transmit paths with single-cycle strobes: copy start (a frame has been accepted and its copy into the slot begins), copy done, remote-frame match, transmit start and transmit done.

On the receive side, a slot that is filled a second time before software empties it moves to an overrun code. A software release that arrives while a copy is still running is held in a dedicated busy code until the copy ends. On the transmit side there are three modes: a one-shot send, an automatic reply to matching remote frames, and a one-shot send after which the slot falls back to automatic reply. A one-cycle event pulse tells the interrupt logic that a receive copy or a transmission has completed.

Top module: `can_buf_state_ctrl`

## Requirements
- R1: After reset the status word, the state, priority and length code read 0 and the event pulse is low.
- R2: The status word holds the state in bits 3:0, the priority in bits 7:4 and the length code in bits 15:12, and all other bits read 0. Every software write loads the priority and length code from those bit positions, whatever the state.
- R3: A software write while the slot is not busy, with no strobe acting on the state in that cycle, loads any even state code (0000, 0010, 0100, 0110, 1000, 1010, 1100, 1110). A written odd code (0001, 0011, 0101, 0111, 1001, 1011, 1101, 1111) leaves the state unchanged.
- R4: A slot in ready (0010) moves to first-copy busy (0011) on copy start. From 0011, copy done moves it to full (0100).
- R5: A slot in full (0100) moves to second-copy busy (0101) on copy start. From 0101, copy done moves it to overrun (0110).
- R6: A slot in overrun (0110) moves to 0111 on copy start. From 0111, copy done returns it to overrun (0110).
- R7: A software write of state 0000 while in 0011, 0101 or 0111 sets the state to 0001. From 0001, copy done moves it to 0000 with no event pulse. Any other state value written during an odd (busy) code is ignored.
- R8: Send-once (1100) moves to 1101 on transmit start. From 1101, transmit done moves it to transmit not-active (1000).
- R9: Send-once-then-reply (1110) moves to 1111 on transmit start. From 1111, transmit done moves it to remote auto-reply (1010).
- R10: In remote auto-reply (1010), a remote-frame match moves the slot to 1111 with no software action. The transmit done that follows returns it to 1010.
- R11: The event pulse is high for exactly one cycle, together with the new state, whenever a copy ends in full or overrun or a transmission ends in 1000 or 1010. It stays low otherwise.
- R12: A strobe that acts on the current state wins over the state field of a software write in the same cycle. A strobe that does not apply to the current state changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_wr_en | input | 1 | Software write strobe for the status word |
| sw_wr_data | input | WORD_W (16) | Status word value to write |
| copy_start | input | 1 | Frame accepted, copy into the slot begins |
| copy_done | input | 1 | Copy into the slot finished |
| rtr_match | input | 1 | Matching remote frame received |
| tx_start | input | 1 | Protocol engine begins sending this slot |
| tx_done | input | 1 | Transmission of this slot completed |
| state | output | 4 | Current life-cycle state code |
| dlc | output | FIELD_W (4) | Stored data length code |
| prio | output | FIELD_W (4) | Stored priority |
| stat_word | output | WORD_W (16) | Assembled status word |
| buf_event | output | 1 | One-cycle completion pulse for interrupt logic |

## Verification
Every strobe and write is sampled at one rising edge. The state, fields and status word carry the result from that same edge, so they are due one cycle after the stimulus. With the default registered event option, the completion pulse is due in that same cycle alongside the new state, and it must be gone one cycle later. The bench drives inputs on the falling edge and compares all outputs on the next falling edge against a bench model that advances one step per cycle. The check is therefore always made exactly one edge after the stimulus, and a pulse that comes a cycle early, a cycle late or lasts too long shows up as a mismatch.

// File: rtl/can_buf_pkg.sv
package can_buf_pkg;

   localparam int STATE_W = 4;

   typedef enum logic [STATE_W-1:0] {
      ST_RX_OFF    = 4'b0000,
      ST_RX_HOLD   = 4'b0001,
      ST_RX_READY  = 4'b0010,
      ST_RX_FILL1  = 4'b0011,
      ST_RX_FULL   = 4'b0100,
      ST_RX_FILL2  = 4'b0101,
      ST_RX_OVR    = 4'b0110,
      ST_RX_FILL3  = 4'b0111,
      ST_TX_OFF    = 4'b1000,
      ST_TX_BAD9   = 4'b1001,
      ST_TX_AUTO   = 4'b1010,
      ST_TX_BADB   = 4'b1011,
      ST_TX_ONCE   = 4'b1100,
      ST_TX_SEND1  = 4'b1101,
      ST_TX_ONCEA  = 4'b1110,
      ST_TX_SEND2  = 4'b1111
   } buf_state_e;

   typedef struct packed {
      logic copy_start;
      logic copy_done;
      logic rtr_match;
      logic tx_start;
      logic tx_done;
   } buf_strobes_t;

   // Odd codes mark a copy or transmission in progress (or are unused).
   function automatic logic is_busy(input logic [STATE_W-1:0] s);
      return s[0];
   endfunction

   function automatic logic is_rx_copy(input logic [STATE_W-1:0] s);
      return (s == ST_RX_FILL1) || (s == ST_RX_FILL2) || (s == ST_RX_FILL3);
   endfunction

endpackage

// File: rtl/can_buf_next_state.sv
module can_buf_next_state
   import can_buf_pkg::*;
(
   input  logic [STATE_W-1:0] cur,
   input  buf_strobes_t       stb,
   input  logic               wr_en,
   input  logic [STATE_W-1:0] wr_state,
   output logic [STATE_W-1:0] nxt,
   output logic               complete
);

   logic hw_hit;

   always_comb begin
      nxt      = cur;
      hw_hit   = 1'b0;
      complete = 1'b0;
      case (cur)
         ST_RX_READY: if (stb.copy_start) begin nxt = ST_RX_FILL1; hw_hit = 1'b1; end
         ST_RX_FULL:  if (stb.copy_start) begin nxt = ST_RX_FILL2; hw_hit = 1'b1; end
         ST_RX_OVR:   if (stb.copy_start) begin nxt = ST_RX_FILL3; hw_hit = 1'b1; end
         ST_RX_FILL1: if (stb.copy_done) begin
            nxt = ST_RX_FULL; hw_hit = 1'b1; complete = 1'b1;
         end
         ST_RX_FILL2, ST_RX_FILL3: if (stb.copy_done) begin
            nxt = ST_RX_OVR; hw_hit = 1'b1; complete = 1'b1;
         end
         ST_RX_HOLD:  if (stb.copy_done) begin nxt = ST_RX_OFF; hw_hit = 1'b1; end
         ST_TX_ONCE:  if (stb.tx_start) begin nxt = ST_TX_SEND1; hw_hit = 1'b1; end
         ST_TX_ONCEA: if (stb.tx_start) begin nxt = ST_TX_SEND2; hw_hit = 1'b1; end
         ST_TX_AUTO:  if (stb.rtr_match) begin nxt = ST_TX_SEND2; hw_hit = 1'b1; end
         ST_TX_SEND1: if (stb.tx_done) begin
            nxt = ST_TX_OFF; hw_hit = 1'b1; complete = 1'b1;
         end
         ST_TX_SEND2: if (stb.tx_done) begin
            nxt = ST_TX_AUTO; hw_hit = 1'b1; complete = 1'b1;
         end
         default: ;
      endcase

      if (wr_en && !hw_hit) begin
         if (is_busy(cur)) begin
            if (is_rx_copy(cur) && (wr_state == ST_RX_OFF))
               nxt = ST_RX_HOLD;
         end else if (!is_busy(wr_state)) begin
            nxt = wr_state;
         end
      end
   end

endmodule

// File: rtl/can_buf_fields.sv
module can_buf_fields #(
   parameter int WORD_W  = 16,
   parameter int FIELD_W = 4,
   parameter int PR_LSB  = 4,
   parameter int DL_LSB  = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [WORD_W-1:0]  wr_data,
   output logic [FIELD_W-1:0] prio,
   output logic [FIELD_W-1:0] dlc
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prio <= '0;
         dlc  <= '0;
      end else if (wr_en) begin
         prio <= wr_data[PR_LSB +: FIELD_W];
         dlc  <= wr_data[DL_LSB +: FIELD_W];
      end
   end

endmodule

// File: rtl/can_buf_event_gen.sv
module can_buf_event_gen #(
   parameter bit EVENT_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic complete,
   output logic pulse
);

   generate
      if (EVENT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse <= 1'b0;
            else        pulse <= complete;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign pulse      = complete;
      end
   endgenerate

endmodule

// File: rtl/can_buf_state_ctrl.sv
module can_buf_state_ctrl
   import can_buf_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int FIELD_W   = 4,
   parameter int ST_LSB    = 0,
   parameter int PR_LSB    = 4,
   parameter int DL_LSB    = 12,
   parameter bit EVENT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sw_wr_en,
   input  logic [WORD_W-1:0]  sw_wr_data,
   input  logic               copy_start,
   input  logic               copy_done,
   input  logic               rtr_match,
   input  logic               tx_start,
   input  logic               tx_done,
   output logic [3:0]         state,
   output logic [FIELD_W-1:0] dlc,
   output logic [FIELD_W-1:0] prio,
   output logic [WORD_W-1:0]  stat_word,
   output logic               buf_event
);

   localparam int ST_END = ST_LSB + STATE_W;
   localparam int PR_END = PR_LSB + FIELD_W;
   localparam int DL_END = DL_LSB + FIELD_W;

   generate
      if (ST_END > PR_LSB || PR_END > DL_LSB || DL_END > WORD_W) begin : g_bad_layout
         $error("can_buf_state_ctrl: status word fields overlap or overflow");
      end
      if (FIELD_W < 1) begin : g_bad_field
         $error("can_buf_state_ctrl: FIELD_W must be positive");
      end
   endgenerate

   buf_strobes_t      stb;
   logic [STATE_W-1:0] st_q, st_d;
   logic              complete;

   assign stb = '{copy_start: copy_start, copy_done: copy_done,
                  rtr_match: rtr_match, tx_start: tx_start, tx_done: tx_done};

   can_buf_next_state u_next (
      .cur      (st_q),
      .stb      (stb),
      .wr_en    (sw_wr_en),
      .wr_state (sw_wr_data[ST_LSB +: STATE_W]),
      .nxt      (st_d),
      .complete (complete)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_RX_OFF;
      else        st_q <= st_d;
   end

   can_buf_fields #(
      .WORD_W  (WORD_W),
      .FIELD_W (FIELD_W),
      .PR_LSB  (PR_LSB),
      .DL_LSB  (DL_LSB)
   ) u_fields (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (sw_wr_en),
      .wr_data (sw_wr_data),
      .prio    (prio),
      .dlc     (dlc)
   );

   can_buf_event_gen #(.EVENT_REG(EVENT_REG)) u_evt (
      .clk      (clk),
      .rst_n    (rst_n),
      .complete (complete),
      .pulse    (buf_event)
   );

   assign state = st_q;

   always_comb begin
      stat_word                     = '0;
      stat_word[ST_LSB +: STATE_W]  = st_q;
      stat_word[PR_LSB +: FIELD_W]  = prio;
      stat_word[DL_LSB +: FIELD_W]  = dlc;
   end

endmodule

// File: rtl/can_buf_state_ctrl_chk.sv
module can_buf_state_ctrl_chk #(
   parameter int WORD_W = 16,
   parameter int ST_LSB = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sw_wr_en,
   input logic [WORD_W-1:0] sw_wr_data,
   input logic              copy_start,
   input logic              copy_done,
   input logic              rtr_match,
   input logic              tx_start,
   input logic              tx_done,
   input logic [3:0]        state,
   input logic              buf_event
);

   logic [3:0] wst;
   logic       any_stb;
   logic       rx_copy;
   assign wst     = sw_wr_data[ST_LSB +: 4];
   assign any_stb = copy_start | copy_done | rtr_match | tx_start | tx_done;
   assign rx_copy = (state == 4'b0011) || (state == 4'b0101) || (state == 4'b0111);

   assert_ready_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 4'b0010 && copy_start) |=> (state == 4'b0011));

   assert_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 4'b0101 && copy_done) |=> (state == 4'b0110));

   assert_refill_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 4'b0111 && copy_done) |=> (state == 4'b0110));

   assert_release_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_copy && !copy_done && sw_wr_en && wst == 4'b0000) |=> (state == 4'b0001));

   assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state[0] && sw_wr_en && !any_stb && !(rx_copy && wst == 4'b0000)) |=> $stable(state));

   assert_once_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 4'b1101 && tx_done) |=> (state == 4'b1000));

   assert_auto_reply_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 4'b1010 && rtr_match) |=> (state == 4'b1111));

   assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      buf_event |=> !buf_event);

endmodule

bind can_buf_state_ctrl can_buf_state_ctrl_chk #(.WORD_W(WORD_W), .ST_LSB(ST_LSB)) u_chk (.*);

// File: tb/can_buf_state_ctrl_test.sv
`timescale 1ns/1ps
module can_buf_state_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_wr_en = 1'b0;
   logic [15:0] sw_wr_data = '0;
   logic        copy_start = 1'b0, copy_done = 1'b0, rtr_match = 1'b0;
   logic        tx_start = 1'b0, tx_done = 1'b0;
   logic [3:0]  state, dlc, prio;
   logic [15:0] stat_word;
   logic        buf_event;

   int n_tests = 0;
   int n_fail  = 0;
   bit done_flag = 1'b0;

   logic [3:0] m_st = 4'h0, m_dlc = 4'h0, m_pr = 4'h0;

   always #10 clk = ~clk;

   can_buf_state_ctrl uut (.*);

   // strobe vector bits: 0 copy_start, 1 copy_done, 2 rtr_match, 3 tx_start, 4 tx_done
   function automatic logic [4:0] model_next(input logic [3:0] s, input logic [4:0] ev,
                                             input logic we, input logic [3:0] ws);
      logic [3:0] n;
      logic       hit, cmp;
      n = s; hit = 1'b0; cmp = 1'b0;
      if (ev[0] && (s == 4'h2 || s == 4'h4 || s == 4'h6)) begin
         hit = 1'b1; n = s + 4'h1;
      end
      if (ev[1]) begin
         if (s == 4'h3) begin hit = 1'b1; cmp = 1'b1; n = 4'h4; end
         if (s == 4'h5 || s == 4'h7) begin hit = 1'b1; cmp = 1'b1; n = 4'h6; end
         if (s == 4'h1) begin hit = 1'b1; n = 4'h0; end
      end
      if (ev[2] && s == 4'hA) begin hit = 1'b1; n = 4'hF; end
      if (ev[3] && (s == 4'hC || s == 4'hE)) begin hit = 1'b1; n = s + 4'h1; end
      if (ev[4]) begin
         if (s == 4'hD) begin hit = 1'b1; cmp = 1'b1; n = 4'h8; end
         if (s == 4'hF) begin hit = 1'b1; cmp = 1'b1; n = 4'hA; end
      end
      if (we && !hit) begin
         if (s[0] == 1'b0) begin
            if (ws[0] == 1'b0) n = ws;
         end else if ((s == 4'h3 || s == 4'h5 || s == 4'h7) && ws == 4'h0) begin
            n = 4'h1;
         end
      end
      return {cmp, n};
   endfunction

   task automatic check(input string tag, input string what, input logic [15:0] act,
                        input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic we, input logic [15:0] wd, input logic [4:0] ev,
                       input string tag);
      logic [4:0] r;
      logic [3:0] e_dlc, e_pr;
      @(negedge clk);
      sw_wr_en   = we;
      sw_wr_data = wd;
      copy_start = ev[0]; copy_done = ev[1]; rtr_match = ev[2];
      tx_start   = ev[3]; tx_done   = ev[4];
      r     = model_next(m_st, ev, we, wd[3:0]);
      e_dlc = we ? wd[15:12] : m_dlc;
      e_pr  = we ? wd[7:4]   : m_pr;
      @(negedge clk);
      sw_wr_en = 1'b0;
      {copy_start, copy_done, rtr_match, tx_start, tx_done} = '0;
      check(tag, "state", {12'h0, state}, {12'h0, r[3:0]});
      check(tag, "event", {15'h0, buf_event}, {15'h0, r[4]});
      check(tag, "word", stat_word, {e_dlc, 4'h0, e_pr, r[3:0]});
      m_st = r[3:0]; m_dlc = e_dlc; m_pr = e_pr;
   endtask

   task automatic finish_run;
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] seed;
      seed = 32'd7;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", "state", {12'h0, state}, 16'h0);
      check("R1", "word", stat_word, 16'h0);
      check("R1", "event", {15'h0, buf_event}, 16'h0);
      rst_n = 1'b1;

      // receive path
      step(1, 16'h5F32, 5'b00000, "R2");      // reserved bits set in data, read as 0
      step(0, 16'h0,    5'b00001, "R4");      // ready -> 0011
      step(1, 16'h0000, 5'b00000, "R7");      // release during copy -> 0001
      step(0, 16'h0,    5'b00010, "R7");      // copy done -> 0000, no pulse
      step(1, 16'h9002, 5'b00000, "R3");
      step(0, 16'h0,    5'b00001, "R4");
      step(0, 16'h0,    5'b00010, "R11");     // -> full, pulse
      step(0, 16'h0,    5'b00000, "R11");     // pulse gone
      step(0, 16'h0,    5'b00001, "R5");      // full -> 0101
      step(1, 16'h3408, 5'b00000, "R7");      // state ignored, fields load
      step(0, 16'h0,    5'b00010, "R5");      // -> overrun
      step(0, 16'h0,    5'b00001, "R6");
      step(0, 16'h0,    5'b00010, "R6");
      step(0, 16'h0,    5'b11100, "R12");     // inapplicable strobes in overrun
      // transmit path
      step(1, 16'h800C, 5'b00000, "R3");
      step(0, 16'h0,    5'b01000, "R8");
      step(0, 16'h0,    5'b10000, "R8");
      step(1, 16'h000E, 5'b00000, "R3");
      step(0, 16'h0,    5'b01000, "R9");
      step(0, 16'h0,    5'b10000, "R9");
      step(0, 16'h0,    5'b00100, "R10");
      step(0, 16'h0,    5'b10000, "R10");
      step(1, 16'h0003, 5'b00000, "R3");      // odd code ignored
      step(1, 16'h0009, 5'b00000, "R3");
      step(0, 16'h0,    5'b01011, "R12");     // not applicable in 1010
      step(1, 16'h0000, 5'b00100, "R12");     // strobe beats write
      step(1, 16'h0002, 5'b10000, "R12");     // strobe beats write

      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic        we;
         logic [15:0] wd;
         logic [4:0]  ev;
         we = ($urandom_range(0, 5) == 0);
         wd = 16'($urandom());
         ev[0] = ($urandom_range(0, 2) == 0);
         ev[1] = ($urandom_range(0, 2) == 0);
         ev[2] = ($urandom_range(0, 3) == 0);
         ev[3] = ($urandom_range(0, 2) == 0);
         ev[4] = ($urandom_range(0, 2) == 0);
         step(we, wd, ev, "R12");
      end
      finish_run();
   end

endmodule